// File: doc/BRIEF.md
# Dirty Page Write Logger

This block watches a stream of guest write requests. Each request carries a guest physical address and a page-size tag for the mapping that the write uses: 4 KB, 2 MB or 1 GB. For each page size the block keeps a small direct-mapped store of dirty bits. A write whose dirty bit is clear sets that bit and appends the written address, rounded down to its 4 KB boundary, to a log buffer of 512 entries. The log fills from the top slot downward. Software reads the entries through a plain index/data read port. It can clear single dirty bits so that a page is tracked again, and a flush pulse empties the log.

The write input is a valid/ready stream. A request counts as taken in a cycle where both `wr_valid` and `wr_ready` are high. While `wr_valid` is high and `wr_ready` is low, the source must hold the address and size steady. `wr_ready` drops in two cases: in any cycle where `flush_req` is high, and when the log is full and the write would need a new entry. A write that hits a dirty bit that is already set is always taken unless a flush is in progress, even when the log is full.

Top module: `dirty_write_logger`

## Requirements
- R1: After reset, `log_idx` is 511, `log_full` is 0, `wr_ready` is 1 and every dirty bit is clear.
- R2: `wr_size` is coded 0 for 4 KB, 1 for 2 MB and 2 for 1 GB; the code 3 is treated as 4 KB. A taken write whose dirty bit is clear sets that bit and logs one entry. The k-th entry since the log was last emptied goes to slot 512-k, and `log_idx` drops by one in the cycle after each entry is written.
- R3: A taken write whose dirty bit is already set writes no entry and leaves `log_idx` unchanged.
- R4: The dirty bit belongs to the page of the size given with the write. After a 2 MB or 1 GB page is marked dirty, writes to other 4 KB regions inside that page are not logged.
- R5: `rd_data` returns the stored entry at slot `rd_idx`. The entry is the write address with bits 11:0 set to zero, and it carries no page-size field.
- R6: After 512 entries, `log_full` is 1 and `log_idx` stays at 0. A write that needs an entry then sees `wr_ready` low until a flush. A write that hits a set dirty bit is still taken, and no dirty bit is set without its entry.
- R7: A `flush_req` pulse sets `log_idx` to 511 and `log_full` to 0 in the next cycle.
- R8: When `flush_req` is high, `wr_ready` is low in that cycle. A held write is taken in the next cycle and logs into slot 511.
- R9: `clr_en` with `clr_addr`/`clr_size` (same size code as in R2) clears the dirty bit of that page. A later write to the page logs again.
- R10: Each page size has 16 dirty slots, selected by the low 4 bits of the page number; each slot holds its full page number as a tag. A write to a page whose slot holds another page is treated as clean: it is logged and takes over the slot. The displaced page logs again on its next write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request taken in this cycle if valid |
| wr_addr | input | 40 | Guest physical address of the write |
| wr_size | input | 2 | Page size of the mapping (0 = 4 KB, 1 = 2 MB, 2 = 1 GB) |
| clr_en | input | 1 | Clear one dirty bit |
| clr_addr | input | 40 | Address inside the page to clear |
| clr_size | input | 2 | Page size of the page to clear |
| flush_req | input | 1 | Empty the log (index back to 511) |
| log_idx | output | 9 | Next free log slot; counts down from 511 |
| log_full | output | 1 | All 512 slots are used |
| rd_idx | input | 9 | Log slot to read |
| rd_data | output | 40 | Logged address at `rd_idx`, bits 11:0 zero |

## Verification
The bench writes inside large pages at addresses other than the page base. A design that logged the page base, or logged every 4 KB region, would give the wrong entry or an extra decrement. Two pages that map to the same 4 KB slot are written in turn: a design without tags would miss the second page, and one that kept the first page's bit would not log it again. The full log is driven with both clean and already-dirty writes. A design that dropped entries, wrapped the index or blocked dirty hits would fail there. A write held over a flush must wait one cycle and then land in slot 511.

// File: rtl/dpl_pkg.sv
package dpl_pkg;
  typedef enum logic [1:0] {
    PG_4K = 2'd0,
    PG_2M = 2'd1,
    PG_1G = 2'd2,
    PG_RSV = 2'd3
  } pg_size_e;

  localparam int NUM_LVL = 3;

  function automatic int lvl_shift(input int lvl);
    case (lvl)
      0: return 12;
      1: return 21;
      default: return 30;
    endcase
  endfunction

  function automatic logic [NUM_LVL-1:0] size_onehot(input logic [1:0] sz);
    case (pg_size_e'(sz))
      PG_2M: return 3'b010;
      PG_1G: return 3'b100;
      default: return 3'b001;
    endcase
  endfunction
endpackage

// File: rtl/dpl_dirty_level.sv
module dpl_dirty_level #(
  parameter int ADDR_W = 40,
  parameter int SHIFT  = 12,
  parameter int SET_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [ADDR_W-1:0] clr_addr,
  output logic              hit
);
  localparam int TAG_W = ADDR_W - SHIFT;
  localparam int SETS  = 1 << SET_W;

  logic [TAG_W-1:0] tag_q [SETS];
  logic [SETS-1:0]  dirty_q;
  logic [TAG_W-1:0] lk_pn, clr_pn;
  logic [SET_W-1:0] lk_set, clr_set;
  logic             clr_match;

  assign lk_pn     = lk_addr[ADDR_W-1:SHIFT];
  assign clr_pn    = clr_addr[ADDR_W-1:SHIFT];
  assign lk_set    = lk_pn[SET_W-1:0];
  assign clr_set   = clr_pn[SET_W-1:0];
  assign hit       = dirty_q[lk_set] && (tag_q[lk_set] == lk_pn);
  assign clr_match = clr_en && dirty_q[clr_set] && (tag_q[clr_set] == clr_pn)
                     && !(set_en && (clr_set == lk_set));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dirty_q <= '0;
    end else begin
      if (set_en)    dirty_q[lk_set]  <= 1'b1;
      if (clr_match) dirty_q[clr_set] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (set_en) tag_q[lk_set] <= lk_pn;
  end

  // R4
  dirty_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> dirty_q[$past(lk_set)]);
endmodule

// File: rtl/dpl_log_buf.sv
module dpl_log_buf #(
  parameter int DEPTH = 512,
  parameter int ENT_W = 28
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ENT_W-1:0]         wr_data,
  input  logic                     flush,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [ENT_W-1:0]         rd_data,
  output logic [$clog2(DEPTH)-1:0] idx,
  output logic                     full
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(DEPTH - 1);

  logic [ENT_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0] idx_q;
  logic             full_q;

  assign idx     = idx_q;
  assign full    = full_q;
  assign rd_data = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= TOP;
      full_q <= 1'b0;
    end else if (flush) begin
      idx_q  <= TOP;
      full_q <= 1'b0;
    end else if (wr_en) begin
      if (idx_q == '0) full_q <= 1'b1;
      else             idx_q  <= idx_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !flush) mem[idx_q] <= wr_data;
  end

  // R7
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (idx_q == TOP) && !full_q);

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full_q);

  // R2
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush && idx_q != '0) |=> idx_q == $past(idx_q) - 1'b1);
endmodule

// File: rtl/dirty_write_logger.sv
module dirty_write_logger
  import dpl_pkg::*;
#(
  parameter int ADDR_W    = 40,
  parameter int LOG_DEPTH = 512,
  parameter int SET_W     = 4,
  localparam int IDX_W    = $clog2(LOG_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_size,
  input  logic              clr_en,
  input  logic [ADDR_W-1:0] clr_addr,
  input  logic [1:0]        clr_size,
  input  logic              flush_req,
  output logic [IDX_W-1:0]  log_idx,
  output logic              log_full,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_data
);
  localparam int ENT_W = ADDR_W - 12;

  logic [NUM_LVL-1:0] wr_sel, clr_sel, lvl_hit;
  logic               hit_sel, log_wr;
  logic [ENT_W-1:0]   ent_rd;

  assign wr_sel   = size_onehot(wr_size);
  assign clr_sel  = size_onehot(clr_size);
  assign hit_sel  = |(lvl_hit & wr_sel);
  assign wr_ready = !flush_req && !(log_full && !hit_sel);
  assign log_wr   = wr_valid && wr_ready && !hit_sel;

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    dpl_dirty_level #(
      .ADDR_W(ADDR_W),
      .SHIFT (lvl_shift(g)),
      .SET_W (SET_W)
    ) u_lvl (
      .clk     (clk),
      .rst_n   (rst_n),
      .lk_addr (wr_addr),
      .set_en  (log_wr && wr_sel[g]),
      .clr_en  (clr_en && clr_sel[g]),
      .clr_addr(clr_addr),
      .hit     (lvl_hit[g])
    );
  end

  dpl_log_buf #(
    .DEPTH(LOG_DEPTH),
    .ENT_W(ENT_W)
  ) u_log (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (log_wr),
    .wr_data(wr_addr[ADDR_W-1:12]),
    .flush  (flush_req),
    .rd_idx (rd_idx),
    .rd_data(ent_rd),
    .idx    (log_idx),
    .full   (log_full)
  );

  assign rd_data = {ent_rd, 12'h000};

  // R8
  flush_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> !wr_ready);

  // R6
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (log_full && !hit_sel) |-> !wr_ready);

  // R3
  hit_no_log_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && hit_sel) |=> $stable(log_idx));
endmodule

// File: tb/tb_dirty_write_logger.sv
module tb_dirty_write_logger;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_valid, wr_ready;
  logic [39:0] wr_addr, clr_addr, rd_data;
  logic [1:0]  wr_size, clr_size;
  logic        clr_en, flush_req, log_full;
  logic [8:0]  log_idx, rd_idx;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  dirty_write_logger dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_size(wr_size), .clr_en(clr_en), .clr_addr(clr_addr),
    .clr_size(clr_size), .flush_req(flush_req), .log_idx(log_idx),
    .log_full(log_full), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  // {addr, size, expect_log}
  localparam int NV = 8;
  localparam logic [42:0] VEC [NV] = '{
    {40'h00_0000_1234, 2'd0, 1'b1},  // R2 fresh 4K
    {40'h00_0000_1ff8, 2'd0, 1'b0},  // R3 same 4K page
    {40'h00_0020_5678, 2'd1, 1'b1},  // R2 R5 2M, inner 4K logged
    {40'h00_003f_f000, 2'd1, 1'b0},  // R4 other 4K in same 2M
    {40'h00_4000_0abc, 2'd2, 1'b1},  // R2 1G
    {40'h00_7fff_f123, 2'd2, 1'b0},  // R4 same 1G
    {40'h00_0001_1000, 2'd0, 1'b1},  // R10 alias into slot 1
    {40'h00_0000_1000, 2'd0, 1'b1}   // R10 displaced page logs again
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [39:0] a, input logic [1:0] s);
    @(negedge clk);
    wr_addr = a; wr_size = s; wr_valid = 1'b1;
    #1;
    while (!wr_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    wr_valid = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush_req = 1'b1;
    @(posedge clk);
    #1;
    flush_req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int exp_idx;
    rst_n = 1'b0; wr_valid = 1'b0; wr_addr = '0; wr_size = '0;
    clr_en = 1'b0; clr_addr = '0; clr_size = '0; flush_req = 1'b0; rd_idx = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 idx", log_idx, 511);
    check("R1 full", log_full, 0);
    check("R1 ready", wr_ready, 1);

    exp_idx = 511;
    for (int i = 0; i < NV; i++) begin
      logic [39:0] a;
      a = VEC[i][42:3];
      do_write(a, VEC[i][2:1]);
      if (VEC[i][0]) begin
        rd_idx = 9'(exp_idx);
        exp_idx--;
        #1;
        check("R5 entry", rd_data, {a[39:12], 12'h000});
      end
      check("R2 R3 idx", log_idx, exp_idx);
    end

    // R9 clear the 2M dirty bit, then a write inside it logs again
    @(negedge clk);
    clr_en = 1'b1; clr_addr = 40'h00_0020_0000; clr_size = 2'd1;
    @(posedge clk); #1 clr_en = 1'b0;
    do_write(40'h00_0030_0000, 2'd1);
    rd_idx = 9'(exp_idx); exp_idx--;
    #1;
    check("R9 relog entry", rd_data, 40'h00_0030_0000);
    check("R9 relog idx", log_idx, exp_idx);

    // R7 flush
    do_flush();
    check("R7 idx", log_idx, 511);
    check("R7 full", log_full, 0);

    // R6 fill all 512 slots
    for (int i = 0; i < 512; i++) do_write(40'(40'h100 + i) << 12, 2'd0);
    #1;
    check("R6 full", log_full, 1);
    check("R6 idx", log_idx, 0);
    rd_idx = 9'd0; #1;
    check("R6 last entry", rd_data, 40'h2ff << 12);
    rd_idx = 9'd511; #1;
    check("R6 first entry", rd_data, 40'h100 << 12);

    @(negedge clk);
    wr_addr = 40'h00_5555_5000; wr_size = 2'd0; wr_valid = 1'b1;
    #1 check("R6 stall", wr_ready, 0);
    repeat (3) @(negedge clk);
    #1 check("R6 stall held", wr_ready, 0);
    check("R6 idx held", log_idx, 0);
    wr_valid = 1'b0;

    do_write(40'h2ff << 12, 2'd0);
    check("R6 dirty hit passes", log_idx, 0);
    check("R6 still full", log_full, 1);

    // R8 flush and pending write in the same cycle
    @(negedge clk);
    wr_addr = 40'h00_9000_0000; wr_size = 2'd0; wr_valid = 1'b1; flush_req = 1'b1;
    #1 check("R8 ready low", wr_ready, 0);
    @(posedge clk); #1 flush_req = 1'b0;
    #1 check("R8 idx after flush", log_idx, 511);
    check("R8 ready next", wr_ready, 1);
    @(posedge clk); #1 wr_valid = 1'b0;
    check("R8 idx after write", log_idx, 510);
    rd_idx = 9'd511; #1;
    check("R8 entry", rd_data, 40'h00_9000_0000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule